// File: doc/BRIEF.md
# Dual-Channel Interrupt Status and Mask Unit

This block collects the ready events of two serial channels into one 8-bit interrupt status word, holds a software-written 8-bit enable mask, and drives one active-low interrupt request. Each channel owns a 4-bit nibble of the word: a transmit-ready bit, a receive-ready bit and two spare source bits. The channels produce these as levels, and the unit passes them through without latching them.

A single register address serves both directions. A read at that address returns the live status word. A write at that address loads the mask. The request line is registered. It goes low in the cycle after any status bit whose mask bit is set becomes 1. It returns high in the cycle after no enabled bit is set any more. Software clears a source by servicing the channel, so no clear write exists.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the mask reads 8'h00 and irq_n is 1.
- R2: For channel c (0 or 1), status bit 4c holds that channel's transmit-ready level, bit 4c+1 holds its receive-ready level, and bits 4c+2 and 4c+3 hold spare inputs 2c and 2c+1.
- R3: When bus_rd is 1 and bus_addr equals 5, bus_rdata equals the live status word in the same cycle, and a bit clears as soon as its source drops. In every other case bus_rdata is 8'h00.
- R4: A clock edge with bus_wr at 1 and bus_addr at 5 loads all eight bits of bus_wdata into the mask. A write to any other address leaves the mask unchanged.
- R5: If (status AND mask) is nonzero at a clock edge, irq_n is 0 after that edge, and not before it.
- R6: If (status AND mask) is zero at a clock edge, irq_n is 1 after that edge. This covers a zero mask with every source active and an active source whose mask bit is clear.
- R7: When a mask write and a source change meet at the same edge, irq_n after that edge follows the mask value from before the write. The new mask takes effect at the following edge. Reads change neither the mask nor irq_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data (mask value) |
| bus_rdata | output | 8 | Read data (live status, zero when not selected) |
| ch_tx_rdy | input | 2 | Transmit-ready level per channel |
| ch_rx_rdy | input | 2 | Receive-ready level per channel |
| ch_spare | input | 4 | Two spare source levels per channel |
| irq_mask | output | 8 | Current mask register |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
A mask load and a change in a source level can arrive on the same edge. This is the case where an unregistered design and a registered one give different results. The bench raises a transmit-ready source in the same cycle as a write that enables only that bit. It then expects irq_n to stay high after the first edge and to fall after the second. The same check also looks at the opposite case: a source that drops while it is still enabled must release the line after one edge, with no write.

// File: rtl/irq_unit_pkg.sv
// Package: shared geometry of the interrupt status word.
// Assumes every channel owns a nibble laid out tx, rx, spare0, spare1 from LSB.
package irq_unit_pkg;
    localparam int NIB_W    = 4;
    localparam int TX_POS   = 0;
    localparam int RX_POS   = 1;
    localparam int SPA_POS  = 2;
    localparam int SPB_POS  = 3;
    localparam int SPARE_PER_CH = 2;
endpackage

// File: rtl/irq_nibble_pack.sv
// Module: assembles per-channel source levels into the combined status word.
// Assumes sources are already synchronous levels; nothing is latched here.
module irq_nibble_pack
    import irq_unit_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int WORD_W = NUM_CH * NIB_W
) (
    input  logic [NUM_CH-1:0]              tx_rdy,
    input  logic [NUM_CH-1:0]              rx_rdy,
    input  logic [NUM_CH*SPARE_PER_CH-1:0] spare,
    output logic [WORD_W-1:0]              stat_word
);
    // One nibble per channel, positions fixed by the package
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign stat_word[c*NIB_W + TX_POS]  = tx_rdy[c];
        assign stat_word[c*NIB_W + RX_POS]  = rx_rdy[c];
        assign stat_word[c*NIB_W + SPA_POS] = spare[c*SPARE_PER_CH];
        assign stat_word[c*NIB_W + SPB_POS] = spare[c*SPARE_PER_CH + 1];
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: holds the interrupt enable mask.
// Assumes the caller has decoded the write strobe for the status address.
module irq_mask_reg #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] mask
);
    // Load the full mask on a decoded write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (load)
            mask <= wdata;
    end
endmodule

// File: rtl/irq_req_drive.sv
// Module: combines status with mask and registers the active-low request.
// Assumes status and mask are stable before the clock edge.
module irq_req_drive #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] stat_word,
    input  logic [WORD_W-1:0] mask,
    output logic              irq_n
);
    logic any_pending;

    // Any enabled source active
    always_comb any_pending = |(stat_word & mask);

    // Register the request so the pin never glitches
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~any_pending;
    end
endmodule

// File: rtl/irq_status_unit.sv
// Module: top of the shared interrupt status and mask unit.
// Assumes one register address: reads give live status, writes load the mask.
module irq_status_unit
    import irq_unit_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 5,
    localparam int WORD_W  = NUM_CH * NIB_W,
    localparam int SPARE_W = NUM_CH * SPARE_PER_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] ch_tx_rdy,
    input  logic [NUM_CH-1:0] ch_rx_rdy,
    input  logic [SPARE_W-1:0] ch_spare,
    output logic [WORD_W-1:0] irq_mask,
    output logic              irq_n
);
    logic              addr_hit;
    logic              wr_hit;
    logic              rd_hit;
    logic [WORD_W-1:0] stat_word;

    // Address decode shared by both directions
    always_comb begin
        addr_hit = (bus_addr == ADDR_W'(STAT_ADDR));
        wr_hit   = bus_wr && addr_hit;
        rd_hit   = bus_rd && addr_hit;
    end

    irq_nibble_pack #(.NUM_CH(NUM_CH)) u_pack (
        .tx_rdy    (ch_tx_rdy),
        .rx_rdy    (ch_rx_rdy),
        .spare     (ch_spare),
        .stat_word (stat_word)
    );

    irq_mask_reg #(.WORD_W(WORD_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_hit),
        .wdata (bus_wdata),
        .mask  (irq_mask)
    );

    irq_req_drive #(.WORD_W(WORD_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_word (stat_word),
        .mask      (irq_mask),
        .irq_n     (irq_n)
    );

    // Read mux: live status when selected, zero otherwise
    always_comb bus_rdata = rd_hit ? stat_word : '0;
endmodule

// File: rtl/irq_status_unit_chk.sv
// Module: protocol checker bound to irq_status_unit; observes ports only.
// Assumes the nibble layout tx, rx, spare0, spare1 per channel.
module irq_status_unit_chk #(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 5,
    localparam int WORD_W  = NUM_CH * 4,
    localparam int SPARE_W = NUM_CH * 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] ch_tx_rdy,
    input logic [NUM_CH-1:0] ch_rx_rdy,
    input logic [SPARE_W-1:0] ch_spare,
    input logic [WORD_W-1:0] irq_mask,
    input logic              irq_n
);
    logic [WORD_W-1:0] exp_stat;
    logic              sel;

    // Expected status built from the source ports
    always_comb begin
        exp_stat = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            exp_stat[4*c]     = ch_tx_rdy[c];
            exp_stat[4*c + 1] = ch_rx_rdy[c];
            exp_stat[4*c + 2] = ch_spare[2*c];
            exp_stat[4*c + 3] = ch_spare[2*c + 1];
        end
        sel = (bus_addr == ADDR_W'(STAT_ADDR));
    end

    // R3
    read_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel) |-> bus_rdata == exp_stat);
    // R3
    read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && sel) |-> bus_rdata == '0);
    // R4
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel) |=> irq_mask == $past(bus_wdata));
    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel) |=> $stable(irq_mask));
    // R5
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(exp_stat & irq_mask)) |=> !irq_n);
    // R6
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(exp_stat & irq_mask)) |=> irq_n);
    // R6
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |=> irq_n);
endmodule

bind irq_status_unit irq_status_unit_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_tx_rdy(ch_tx_rdy), .ch_rx_rdy(ch_rx_rdy), .ch_spare(ch_spare),
    .irq_mask(irq_mask), .irq_n(irq_n)
);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [1:0] tx = '0;
    logic [1:0] rx = '0;
    logic [3:0] spare = '0;
    logic [7:0] rdata;
    logic [7:0] mask;
    logic       irq_n;

    int  checks = 0;
    int  fails = 0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;

    logic [7:0] m_mask;
    logic       m_irq_n;

    always #4 clk = ~clk;

    irq_status_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .ch_tx_rdy(tx), .ch_rx_rdy(rx),
        .ch_spare(spare), .irq_mask(mask), .irq_n(irq_n)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural status word: channel c nibble = {spare1, spare0, rx, tx}
    function automatic logic [7:0] model_stat();
        logic [7:0] s = '0;
        for (int c = 0; c < 2; c++) begin
            s[4*c]     = tx[c];
            s[4*c + 1] = rx[c];
            s[4*c + 2] = spare[2*c];
            s[4*c + 3] = spare[2*c + 1];
        end
        return s;
    endfunction

    // Reference model updated on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask  <= 8'h00;
            m_irq_n <= 1'b1;
        end else begin
            m_irq_n <= ((model_stat() & m_mask) == 8'h00);
            if (wr && addr == 4'd5) m_mask <= wdata;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R4", "mask", mask, m_mask);
            chk("R5", "irq_n", {7'b0, irq_n}, {7'b0, m_irq_n});
            chk("R3", "rdata", rdata, (rd && addr == 4'd5) ? model_stat() : 8'h00);
        end
    end

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        after_edge();
        addr = a; wr = 1'b1; wdata = d;
        after_edge();
        wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_en = 1'b1;
        // R1: reset state
        chk("R1", "mask after reset", mask, 8'h00);
        chk("R1", "irq_n after reset", {7'b0, irq_n}, 8'h01);

        // R2: bit layout on live reads
        rd = 1'b1; addr = 4'd5;
        tx = 2'b01; #1 chk("R2", "ch0 tx bit0", rdata, 8'h01);
        tx = 2'b00; rx = 2'b01; #1 chk("R2", "ch0 rx bit1", rdata, 8'h02);
        rx = 2'b00; tx = 2'b10; #1 chk("R2", "ch1 tx bit4", rdata, 8'h10);
        tx = 2'b00; rx = 2'b10; #1 chk("R2", "ch1 rx bit5", rdata, 8'h20);
        rx = 2'b00; #1 chk("R2", "spares tied low", rdata, 8'h00);
        tx = 2'b11; rx = 2'b11; #1 chk("R3", "all live", rdata, 8'h33);
        rd = 1'b0; #1 chk("R3", "no read strobe", rdata, 8'h00);
        rd = 1'b1; addr = 4'd6; #1 chk("R3", "other address", rdata, 8'h00);
        rd = 1'b0; addr = 4'd0;

        // R6: zero mask with all sources active
        repeat (3) after_edge();
        chk("R6", "zero mask keeps line high", {7'b0, irq_n}, 8'h01);

        // R4: writes elsewhere ignored, write at 5 loads
        bus_write(4'd3, 8'hFF);
        chk("R4", "write to other address", mask, 8'h00);
        tx = 2'b00; rx = 2'b00;
        bus_write(4'd5, 8'h22);
        chk("R4", "mask loaded", mask, 8'h22);
        after_edge();

        // R5: rise one cycle after the enabled source
        rx = 2'b10;
        @(negedge clk);
        chk("R5", "not before edge", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        chk("R5", "low after edge", {7'b0, irq_n}, 8'h00);

        // R7: reads do not disturb mask or line
        rd = 1'b1; addr = 4'd5;
        repeat (2) @(negedge clk);
        chk("R7", "mask after reads", mask, 8'h22);
        chk("R7", "irq after reads", {7'b0, irq_n}, 8'h00);
        rd = 1'b0;

        // R6: servicing the source releases the line without a write
        after_edge();
        rx = 2'b00;
        rd = 1'b1; #1 chk("R3", "bit clears with source", rdata, 8'h00); rd = 1'b0;
        @(negedge clk);
        chk("R6", "still low before edge", {7'b0, irq_n}, 8'h00);
        @(negedge clk);
        chk("R6", "released", {7'b0, irq_n}, 8'h01);

        // R6: active source with mask bit clear
        after_edge();
        tx = 2'b01;
        repeat (2) @(negedge clk);
        chk("R6", "masked-off source", {7'b0, irq_n}, 8'h01);
        tx = 2'b00;

        // R7: same-edge mask write and source rise
        after_edge();
        tx = 2'b01; addr = 4'd5; wr = 1'b1; wdata = 8'h01;
        after_edge();
        wr = 1'b0;
        @(negedge clk);
        chk("R7", "old mask used at write edge", {7'b0, irq_n}, 8'h01);
        chk("R7", "new mask visible", mask, 8'h01);
        @(negedge clk);
        chk("R7", "new mask takes effect", {7'b0, irq_n}, 8'h00);

        tx = 2'b00;
        repeat (3) after_edge();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule